// File: doc/BRIEF.md
# Asynchronous static RAM controller

This block lets clocked logic read and write an external 32K-word by 8-bit asynchronous static RAM whose data pins serve both directions. A request holds a 15-bit word address, a read/write flag and, for writes, one data byte. The controller turns each request into the memory's active-low chip-select, output-enable and write-strobe sequence. It holds the address steady for the memory's access time, counted in whole clock cycles, and turns the data pins around only when the memory cannot be driving them. The memory pins are split into an outgoing byte, a driver enable and an incoming byte, so that the pad ring can build the three-state buffer.

Requests arrive on a valid/ready handshake. A request transfers in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so a requester that holds `req_valid` just waits. The request fields are copied at transfer and may change afterwards. Read results leave on `rsp_valid`, a single-cycle pulse with the byte on `rsp_rdata`. The response has no ready, so the consumer must take the byte in that cycle. The byte stays on `rsp_rdata` until the next read finishes.

The wait counts come from the parameters `CLK_PS`, `T_AA_PS` and `T_WC_PS`. The read hold is the ceiling of address access time over the clock period. The write strobe hold is the ceiling of write cycle time over the period. Each count is at least one cycle.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset and in every idle cycle, chip select, output enable and write strobe are high (inactive), the data driver is off and `req_ready` is high.
- R2: A request transfers only when `req_valid` and `req_ready` are both high. `req_ready` is low in every cycle where chip select is low. Request fields that change after transfer have no effect on the access.
- R3: A read keeps chip select low, output enable low and the write strobe high for exactly RD = max(1, ceil(T_AA_PS/CLK_PS)) cycles, starting the cycle after transfer. The address stays stable for the whole read.
- R4: The byte on the data input pins in the last read cycle appears on `rsp_rdata` with a one-cycle `rsp_valid` pulse in the cycle after that, which is RD+1 cycles after transfer. `rsp_rdata` then holds its value until the next read completes.
- R5: A write runs as follows, with output enable high throughout:
  - one cycle with chip select low and the write strobe high;
  - one cycle with the write strobe low and the driver off;
  - exactly WR = max(1, ceil(T_WC_PS/CLK_PS)) cycles with the write strobe low and the driver on.
- R6: The write strobe rises while the driver, data and address are still held. The driver turns off in the following cycle, together with chip select going high. `req_ready` returns WR+4 cycles after transfer.
- R7: The data driver is never on in a cycle where output enable is low, nor in the cycle right after one.
- R8: Chip select falls only after a cycle with all three enables high and the driver off.
- R9: Each byte written to any 15-bit address reads back unchanged, and writes to distinct addresses do not disturb each other.
- R10: A new request may transfer in the same cycle that `rsp_valid` is high, and it starts its access in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-result strobe |
| rsp_rdata | output | 8 | Read byte, held until next read completes |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_o | output | 8 | Byte to drive onto the memory data pins |
| mem_dq_oe | output | 1 | Driver enable for the memory data pins |
| mem_dq_i | input | 8 | Byte sensed on the memory data pins |

## Verification
Two events can coincide in one cycle: the end of a read (the `rsp_valid` pulse) and the transfer of the next request, since the controller is idle in that cycle. The bench provokes this by holding `req_valid` high across back-to-back read-read and read-write pairs. It judges that the strobe carries the first word and that chip select is low in the next cycle. It also judges that `rsp_rdata` still holds the first word while the second access runs. The behavioural memory in the bench returns a junk byte until the address has been held in read mode for RD cycles, and it flags any driver overlap around the read-to-write turnaround.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WADDR, ST_WLOW, ST_WDRIVE, ST_WEND
  } asram_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drv;
    logic idle;
  } asram_pins_t;

  function automatic int unsigned wait_cycles(input int unsigned t_ps,
                                              input int unsigned clk_ps);
    int unsigned q;
    q = (t_ps + clk_ps - 1) / clk_ps;
    return (q < 1) ? 1 : q;
  endfunction

  function automatic asram_pins_t pins_of(input asram_state_e s);
    asram_pins_t p;
    p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0, idle: 1'b0};
    unique case (s)
      ST_IDLE:   p.idle = 1'b1;
      ST_READ:   begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
      ST_WADDR:  p.ce_n = 1'b0;
      ST_WLOW:   begin p.ce_n = 1'b0; p.we_n = 1'b0; end
      ST_WDRIVE: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.drv = 1'b1; end
      ST_WEND:   begin p.ce_n = 1'b0; p.drv = 1'b1; end
      default:   p.idle = 1'b1;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned RD_CYC = 1,
  parameter int unsigned WR_CYC = 1,
  parameter int unsigned CW     = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_fire,
  input  logic          req_write,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          capture,
  output asram_pins_t   pins_q,
  output logic          rsp_valid
);
  asram_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = CW'(RD_CYC - 1);
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_fire) begin
        if (req_write) state_d = ST_WADDR;
        else begin
          state_d  = ST_READ;
          tmr_load = 1'b1;
        end
      end
      ST_READ: if (tmr_done) begin
        capture = 1'b1;
        state_d = ST_IDLE;
      end
      ST_WADDR: state_d = ST_WLOW;
      ST_WLOW: begin
        state_d  = ST_WDRIVE;
        tmr_load = 1'b1;
        tmr_val  = CW'(WR_CYC - 1);
      end
      ST_WDRIVE: if (tmr_done) state_d = ST_WEND;
      ST_WEND:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pins_q    <= pins_of(ST_IDLE);
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      pins_q    <= pins_of(state_d);
      rsp_valid <= capture;
    end
  end
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_fire,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (req_fire) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= mem_dq_i;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_PS  = 20000,
  parameter int unsigned T_AA_PS = 10000,
  parameter int unsigned T_WC_PS = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned RD_CYC  = wait_cycles(T_AA_PS, CLK_PS);
  localparam int unsigned WR_CYC  = wait_cycles(T_WC_PS, CLK_PS);
  localparam int unsigned MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int unsigned CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic          fire, tmr_load, tmr_done, capture;
  logic [CW-1:0] tmr_val;
  asram_pins_t   pins_q;

  assign fire = req_valid && req_ready;

  asram_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  asram_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .req_fire(fire), .req_write(req_write),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .capture(capture), .pins_q(pins_q), .rsp_valid(rsp_valid)
  );

  asram_datapath #(.AW(ADDR_W), .DW(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .req_fire(fire), .req_addr(req_addr),
    .req_wdata(req_wdata), .capture(capture), .mem_dq_i(mem_dq_i),
    .addr_q(mem_addr), .wdata_q(mem_dq_o), .rdata_q(rsp_rdata)
  );

  assign req_ready = pins_q.idle;
  assign mem_ce_n  = pins_q.ce_n;
  assign mem_oe_n  = pins_q.oe_n;
  assign mem_we_n  = pins_q.we_n;
  assign mem_dq_oe = pins_q.drv;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !req_ready);

  assert_read_mode_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_strobe_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_drive_only_write_R5: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

  assert_we_rise_held_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_we_n) && !mem_ce_n) |-> (mem_dq_oe && $stable(mem_dq_o) && $stable(mem_addr)));

  assert_release_with_cs_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_dq_oe) |-> mem_ce_n);

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |=> !mem_dq_oe);

  assert_gap_before_cs_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> ($past(mem_oe_n) && $past(mem_we_n) && !$past(mem_dq_oe)));
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
  localparam int CLK_PS = 20000;
  localparam int T_AA   = 45000;
  localparam int T_WC   = 25000;
  localparam int RDC    = (T_AA + CLK_PS - 1) / CLK_PS;
  localparam int WRC    = (T_WC + CLK_PS - 1) / CLK_PS;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_o;
  logic [7:0]  mem_dq_i = 8'h5A;
  logic [14:0] mem_addr;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] model [int];
  logic [7:0] expm  [int];

  always #10ns clk = ~clk;

  asram_ctrl #(.CLK_PS(CLK_PS), .T_AA_PS(T_AA), .T_WC_PS(T_WC)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  function automatic logic [7:0] rd_model(input logic [14:0] a);
    return model.exists(int'(a)) ? model[int'(a)] : 8'h00;
  endfunction

  // behavioural memory and pin monitor, sampled at the falling edge
  logic        p_ce = 1, p_oe = 1, p_we = 1, p_drv = 0, p_rd = 0;
  logic [14:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  int          rd_age = 0, wr_age = 0;

  always @(negedge clk) begin
    logic rdmode;
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst) begin
      rdmode = !mem_ce_n && !mem_oe_n && mem_we_n;
      if (rdmode) rd_age = (p_rd && mem_addr == p_addr) ? rd_age + 1 : 1;
      else        rd_age = 0;
      mem_dq_i = (rdmode && rd_age >= RDC) ? rd_model(mem_addr) : 8'h5A;
      if (mem_dq_oe && (!mem_oe_n || !p_oe))
        chk(1'b0, "R7 driver overlaps output enable", 1, 0);
      if (p_we && !mem_we_n)
        chk(!mem_dq_oe && !p_ce && mem_oe_n, "R5 strobe falls before driving",
            {mem_dq_oe, p_ce, mem_oe_n}, 3'b001);
      if (!mem_we_n && mem_dq_oe) wr_age++;
      if (!p_we && mem_we_n && !mem_ce_n) begin
        chk(wr_age == WRC, "R5 driven strobe length", wr_age, WRC);
        chk(p_drv && mem_dq_oe && mem_dq_o == p_dq && mem_addr == p_addr,
            "R6 data held at strobe rise", {mem_dq_oe, mem_dq_o}, {1'b1, p_dq});
        model[int'(mem_addr)] = mem_dq_o;
        wr_age = 0;
      end
      if (mem_ce_n) wr_age = 0;
      p_rd = rdmode;
    end
    p_ce = mem_ce_n; p_oe = mem_oe_n; p_we = mem_we_n; p_drv = mem_dq_oe;
    p_addr = mem_addr; p_dq = mem_dq_o;
  end

  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    int n;
    req_write = 1'b1; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk); n = 1;
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;   // R2: late changes ignored
    chk(!req_ready && !mem_ce_n && mem_addr == a, "R2 write captured", mem_addr, a);
    while (!req_ready && n < 60) begin @(negedge clk); n++; end
    chk(n == WRC + 4, "R6 write ready latency", n, WRC + 4);
    chk(mem_ce_n && !mem_dq_oe, "R6 release with chip select", {mem_ce_n, mem_dq_oe}, 2'b10);
    expm[int'(a)] = d;
  endtask

  task automatic do_read(input logic [14:0] a);
    int n;
    logic [7:0] e;
    e = expm.exists(int'(a)) ? expm[int'(a)] : 8'h00;
    req_write = 1'b0; req_addr = a; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk); n = 1;
    req_valid = 1'b0; req_addr = ~a;
    chk(!mem_ce_n && !mem_oe_n && mem_we_n && mem_addr == a, "R3 read mode",
        {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
    while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
    chk(n == RDC + 1, "R4 read latency", n, RDC + 1);
    chk(rsp_rdata == e, "R9 read data", rsp_rdata, e);
    @(negedge clk);
    chk(!rsp_valid && rsp_rdata == e, "R4 pulse and hold", {rsp_valid, rsp_rdata}, {1'b0, e});
  endtask

  // second request held so it transfers in the strobe cycle of the first read
  task automatic b2b(input logic [14:0] a1, input logic [14:0] a2, input bit wr2,
                     input logic [7:0] d2);
    int n;
    logic [7:0] e1;
    e1 = expm.exists(int'(a1)) ? expm[int'(a1)] : 8'h00;
    req_write = 1'b0; req_addr = a1; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk); n = 1;
    req_write = wr2; req_addr = a2; req_wdata = d2;
    while (n < RDC + 1) begin @(negedge clk); n++; end
    chk(rsp_valid && req_ready && rsp_rdata == e1, "R10 strobe with transfer",
        {rsp_valid, req_ready, rsp_rdata}, {2'b11, e1});
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_ce_n && !rsp_valid && rsp_rdata == e1 && mem_addr == a2,
        "R10 next access starts", {mem_ce_n, rsp_rdata}, {1'b0, e1});
    if (wr2) begin
      while (!req_ready) @(negedge clk);
      expm[int'(a2)] = d2;
      do_read(a2);
    end else begin
      e1 = expm.exists(int'(a2)) ? expm[int'(a2)] : 8'h00;
      while (!rsp_valid) @(negedge clk);
      chk(rsp_rdata == e1, "R10 second read data", rsp_rdata, e1);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid,
        "R1 reset state", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid},
        6'b111010);
    // R9 sweep over addresses that touch every address bit
    for (int i = 0; i < 256; i++) do_write(15'((i * 129) & 32'h7FFF), 8'((i * 7 + 3) & 255));
    do_write(15'h7FFF, 8'hC3);
    for (int i = 0; i < 256; i++) do_read(15'((i * 129) & 32'h7FFF));
    do_read(15'h7FFF);
    for (int b = 0; b < 15; b++) begin
      do_write(15'(1 << b), 8'(8'h80 | b));
      do_read(15'(1 << b));
    end
    // R10 and R7: back-to-back turnarounds
    b2b(15'h0081, 15'h7FFF, 1'b0, 8'h00);
    b2b(15'h7FFF, 15'h1234, 1'b1, 8'hA7);
    b2b(15'h1234, 15'h0000, 1'b1, 8'h5B);
    do_read(15'h0081);
    repeat (3) @(negedge clk);
    chk(req_ready && mem_ce_n, "R8 idle after traffic", {req_ready, mem_ce_n}, 2'b11);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule